// File: doc/BRIEF.md
# Bit-Order Selectable Serial Shift Slice

This block is one 32-bit slice of a general-purpose serial engine, used to emulate SPI-style links. A host write loads a word into the slice's shift register. A serial clock generator outside the block supplies a one-cycle leading-edge strobe and a one-cycle trailing-edge strobe for each bit period. The register always shifts right. The serial output always comes from the lowest bit. Each received bit enters at the top. Two load selections exist: one stores the word as written, so the least significant bit goes out first. The other stores it mirrored, so the most significant bit goes out first with no software reversal and no extra cycles.

A programmable length sets how many bits one transfer carries. The slice runs from the load until that many samples have been taken, then raises a one-cycle done pulse. The captured word can then be read in natural order or mirrored. A load that arrives while a transfer is running is dropped and sets a sticky overrun flag.

The load port is a plain strobe, not a valid/ready pair. It never back-pressures: it accepts a write whenever the slice is idle and drops it otherwise, so the sender must watch `busy`. The strobes and status pins are plain levels sampled on `clk`.

Top module: `bitorder_shift_slice`

## Requirements
- R1: After reset, `sout`, `busy`, `done`, `err_overrun`, `rx_word` and `rx_word_rev` are all 0.
- R2: A write with `wr_rev`=0 while idle loads `wr_data` unchanged, so the bits leave on `sout` in the order bit 0, bit 1, bit 2 and so on.
- R3: A write with `wr_rev`=1 while idle loads `wr_data` mirrored (bit i goes to bit 31-i), so bit 31 of `wr_data` leaves first.
- R4: In the cycle after an accepted write, `sout` already shows the first bit to be sent, in both phase modes and before any strobe.
- R5: With `cpha`=0, each `edge_lead` is the sample edge and each `edge_trail` moves `sout` on to the next bit. With `cpha`=1 the two roles swap. On a sample edge the register shifts right by one and `sin` enters bit 31.
- R6: `len_m1` (0..31) sets N = `len_m1`+1 samples per transfer. `busy` is 1 from the cycle after an accepted write up to and including the cycle of the N-th sample edge, and 0 after that.
- R7: `done` is high for exactly the one cycle that follows the N-th sample edge.
- R8: After N samples, `rx_word` equals the loaded word shifted right by N, with the received bits in the top N positions: the first received bit sits at bit 32-N and the last at bit 31. `rx_word_rev` is always `rx_word` mirrored.
- R9: A write while `busy` is 1 has no effect on the transfer and sets `err_overrun`. This includes a write in the same cycle as the final sample edge. `err_overrun` stays 1 until reset.
- R10: Strobes that arrive while idle change neither `rx_word` nor `sout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpha | input | 1 | Phase mode: 0 samples on leading edge, 1 samples on trailing edge |
| edge_lead | input | 1 | One-cycle strobe marking a leading serial clock edge |
| edge_trail | input | 1 | One-cycle strobe marking a trailing serial clock edge |
| sin | input | 1 | Serial input bit |
| wr_en | input | 1 | Load strobe |
| wr_rev | input | 1 | Load selection: 1 stores the word mirrored |
| wr_data | input | 32 | Word to load |
| len_m1 | input | 5 | Transfer length minus one |
| sout | output | 1 | Serial output bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_overrun | output | 1 | Sticky flag: write arrived during a transfer |
| rx_word | output | 32 | Shift register contents, natural order |
| rx_word_rev | output | 32 | Shift register contents, mirrored |

## Verification
A load request and the final sample edge can land in the same clock cycle. In that cycle `busy` is still high, so the write must be dropped even though the slice goes idle on that same edge. The bench provokes this by raising `wr_en`, with inverted data and the opposite load selection, together with the last sample strobe. It also raises a write together with a mid-transfer strobe. In both cases it judges that the done pulse, the captured word and the output sequence match the undisturbed expectation, and that the overrun flag is set.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  typedef enum logic {
    PH_SAMPLE_LEAD  = 1'b0,
    PH_SAMPLE_TRAIL = 1'b1
  } phase_e;
endpackage

// File: rtl/ssl_bitrev.sv
module ssl_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/ssl_launch.sv
module ssl_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ld_bit,
  input  logic launch,
  input  logic cur_bit,
  output logic sout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sout <= 1'b0;
    else if (load)   sout <= ld_bit;
    else if (launch) sout <= cur_bit;
  end

  // R4
  load_presents_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sout == $past(ld_bit)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !launch) |=> $stable(sout));
endmodule

// File: rtl/ssl_core.sv
module ssl_core #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  ld_word,
  input  logic [CW-1:0] len_m1,
  input  logic          sample,
  input  logic          sin,
  output logic          accept,
  output logic [W-1:0]  sreg,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic [CW:0] cnt;
  logic        take;

  assign accept = wr_req && !busy;
  assign take   = sample && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        sreg <= ld_word;
        cnt  <= {1'b0, len_m1} + 1'b1;
        busy <= 1'b1;
      end else if (take) begin
        sreg <= {sin, sreg[W-1:1]};
        cnt  <= cnt - 1'b1;
        if (cnt == 1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 err <= 1'b0;
    else if (wr_req && busy)    err <= 1'b1;
  end

  // R6
  busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != 0));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy) |=> err);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_req) |=> $stable(sreg));
endmodule

// File: rtl/bitorder_shift_slice.sv
module bitorder_shift_slice #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpha,
  input  logic          edge_lead,
  input  logic          edge_trail,
  input  logic          sin,
  input  logic          wr_en,
  input  logic          wr_rev,
  input  logic [W-1:0]  wr_data,
  input  logic [CW-1:0] len_m1,
  output logic          sout,
  output logic          busy,
  output logic          done,
  output logic          err_overrun,
  output logic [W-1:0]  rx_word,
  output logic [W-1:0]  rx_word_rev
);
  import ssl_pkg::*;

  phase_e       phase;
  logic [W-1:0] wr_mirror;
  logic [W-1:0] ld_word;
  logic         accept;
  logic         sample_stb;
  logic         launch_stb;

  assign phase      = phase_e'(cpha);
  assign sample_stb = (phase == PH_SAMPLE_LEAD) ? edge_lead  : edge_trail;
  assign launch_stb = busy && ((phase == PH_SAMPLE_LEAD) ? edge_trail : edge_lead);

  ssl_bitrev #(.W(W)) u_ld_rev (.din(wr_data), .dout(wr_mirror));
  assign ld_word = wr_rev ? wr_mirror : wr_data;

  ssl_core #(.W(W), .CW(CW)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_en),
    .ld_word (ld_word),
    .len_m1  (len_m1),
    .sample  (sample_stb),
    .sin     (sin),
    .accept  (accept),
    .sreg    (rx_word),
    .busy    (busy),
    .done    (done),
    .err     (err_overrun)
  );

  ssl_launch u_launch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .ld_bit  (ld_word[0]),
    .launch  (launch_stb),
    .cur_bit (rx_word[0]),
    .sout    (sout)
  );

  ssl_bitrev #(.W(W)) u_rx_rev (.din(rx_word), .dout(rx_word_rev));
endmodule

// File: tb/bitorder_shift_slice_tb.sv
module bitorder_shift_slice_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpha = 1'b0, edge_lead = 1'b0, edge_trail = 1'b0, sin = 1'b0;
  logic        wr_en = 1'b0, wr_rev = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  len_m1 = '0;
  logic        sout, busy, done, err_overrun;
  logic [31:0] rx_word, rx_word_rev;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bitorder_shift_slice u_dut (
    .clk(clk), .rst_n(rst_n), .cpha(cpha), .edge_lead(edge_lead),
    .edge_trail(edge_trail), .sin(sin), .wr_en(wr_en), .wr_rev(wr_rev),
    .wr_data(wr_data), .len_m1(len_m1), .sout(sout), .busy(busy),
    .done(done), .err_overrun(err_overrun), .rx_word(rx_word),
    .rx_word_rev(rx_word_rev)
  );

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer(input bit mode, input bit rv, input int n,
                      input logic [31:0] d, input logic [31:0] sw, input int poke);
    logic [31:0] ld, ex;
    logic [63:0] cat;
    string tg;
    ld = rv ? rev32(d) : d;
    tg = rv ? "R3" : "R2";
    cpha = mode; wr_en = 1'b1; wr_rev = rv; wr_data = d; len_m1 = 5'(n - 1);
    @(negedge clk);
    wr_en = 1'b0;
    chk(sout === ld[0], "R4", {31'b0, sout}, {31'b0, ld[0]});
    chk(busy === 1'b1, "R6", {31'b0, busy}, 32'd1);
    for (int k = 0; k < n; k++) begin
      if (!mode) begin
        chk(sout === ld[k], tg, {31'b0, sout}, {31'b0, ld[k]});
        sin = sw[k]; edge_lead = 1'b1;
      end else begin
        edge_lead = 1'b1;
        @(negedge clk);
        edge_lead = 1'b0;
        chk(sout === ld[k], "R5", {31'b0, sout}, {31'b0, ld[k]});
        sin = sw[k]; edge_trail = 1'b1;
      end
      if (k == poke) begin wr_en = 1'b1; wr_data = ~d; wr_rev = ~rv; end
      @(negedge clk);
      edge_lead = 1'b0; edge_trail = 1'b0; wr_en = 1'b0;
      if (k == n - 1) begin
        chk(done === 1'b1, "R7", {31'b0, done}, 32'd1);
        chk(busy === 1'b0, "R6", {31'b0, busy}, 32'd0);
      end else begin
        chk(done === 1'b0, "R7", {31'b0, done}, 32'd0);
      end
      if (!mode) begin
        edge_trail = 1'b1;
        @(negedge clk);
        edge_trail = 1'b0;
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R7", {31'b0, done}, 32'd0);
    cat = {sw, ld};
    ex = 32'(cat >> n);
    chk(rx_word === ex, "R8", rx_word, ex);
    chk(rx_word_rev === rev32(ex), "R8", rx_word_rev, rev32(ex));
    if (poke >= 0) chk(err_overrun === 1'b1, "R9", {31'b0, err_overrun}, 32'd1);
  endtask

  initial begin
    logic [31:0] keep_rx;
    logic        keep_out;
    int lens[6] = '{1, 2, 7, 16, 31, 32};
    repeat (2) @(negedge clk);
    // R1 reset state, checked while reset is still held
    chk({sout, busy, done, err_overrun} === 4'b0, "R1", {28'b0, sout, busy, done, err_overrun}, 32'd0);
    chk(rx_word === 32'd0 && rx_word_rev === 32'd0, "R1", rx_word, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++)
        for (int li = 0; li < 6; li++)
          for (int p = 0; p < 2; p++)
            xfer(m[0], r[0], lens[li],
                 p ? 32'hC35A_0F81 : 32'h8000_0001 ^ (32'h1 << li),
                 p ? 32'h6B2D_94E7 : ~(32'h0F0F_3C3C << m), -1);
    chk(err_overrun === 1'b0, "R9", {31'b0, err_overrun}, 32'd0);
    // R10 idle strobes leave register and output untouched
    keep_rx = rx_word; keep_out = sout;
    for (int i = 0; i < 4; i++) begin
      sin = ~sin; edge_lead = i[0]; edge_trail = ~i[0];
      @(negedge clk);
    end
    edge_lead = 1'b0; edge_trail = 1'b0;
    @(negedge clk);
    chk(rx_word === keep_rx, "R10", rx_word, keep_rx);
    chk(sout === keep_out, "R10", {31'b0, sout}, {31'b0, keep_out});
    // R9 write during transfer, mid-stream and coinciding with the last sample
    for (int m = 0; m < 2; m++) begin
      do_reset();
      xfer(m[0], 1'b0, 6, 32'h0000_002D, 32'h0000_0015, 2);
      do_reset();
      xfer(m[0], 1'b1, 6, 32'hB400_0000, 32'h0000_002A, 5);
      chk(busy === 1'b0, "R9", {31'b0, busy}, 32'd0);
      chk(err_overrun === 1'b1, "R9", {31'b0, err_overrun}, 32'd1);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule